// File: doc/BRIEF.md
# Grouped-Priority Exception Arbiter

This block picks which exception an interrupt controller should present next to a processor core, and works out how urgent the core's current work is. It watches a table of exception vectors. Each vector carries three flags (enabled, pending, active) and a priority. The table is fed in as packed buses. Vector 0 is a placeholder and never takes part. Vectors 1, 2 and 3 are the three fixed system levels, with priorities -3, -2 and -1. Every higher vector takes its priority from an unsigned byte. A smaller number always means more urgent.

A grouping field splits each priority into a group part and a subpriority part. Only the group part decides whether one handler can interrupt another. The block also folds in the core's masking state: a fault mask bit, a global mask bit and a base-priority threshold. From these it produces:
- the winning pending vector and its priority;
- the group-masked priority of the active handlers;
- the core's execution priority;
- an interrupt request line;
- a "may take now" indication.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge. The ports are plain control and status signals with no handshake, because the table is presented continuously rather than streamed.

Top module: `pgrp_irq_arb`

## Requirements
- R1: While `rst_n` is low, the outputs are: `pend_vec_o`=0, `pend_prio_o`=256, `act_prio_o`=256, `exec_prio_o`=256, `irq_o`=0, `take_o`=0.
- R2: Among vectors 1..NUM_VEC-1 that are both enabled and pending, `pend_vec_o` names the one with the numerically smallest effective priority, and `pend_prio_o` gives that priority. On a tie, the lowest vector number wins. If no vector qualifies, the outputs are vector 0 and priority 256.
- R3: The flags of vector 0 have no effect on any output.
- R4: The effective priorities of vectors 1, 2 and 3 are -3, -2 and -1, whatever their priority bytes hold. For every vector v of 4 or above, the effective priority is the unsigned value of `prio_i[8v+7:8v]`.
- R5: The group mask is all ones shifted left by (`grp_i`+1), taken as a 10-bit two's-complement value. `act_prio_o` is the minimum effective priority over the active vectors 1..NUM_VEC-1, ANDed with this mask. If no vector is active, `act_prio_o` is 256.
- R6: A running level is chosen in this order: -1 if `faultmask_i` is set; otherwise 0 if `primask_i` is set; otherwise `basepri_i` ANDed with the group mask if `basepri_i` is non-zero; otherwise 256. `exec_prio_o` is the minimum of the running level and the active priority.
- R7: `irq_o` is 1 exactly when the pending priority is below the active priority (signed compare). The mask inputs have no effect on it.
- R8: `take_o` is 1 exactly when the execution priority is above the pending priority (signed compare).
- R9: Every output changes only on a rising clock edge, and reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_en_i | input | NUM_VEC | Enabled flag, one bit per vector |
| vec_pend_i | input | NUM_VEC | Pending flag, one bit per vector |
| vec_act_i | input | NUM_VEC | Active flag, one bit per vector |
| prio_i | input | NUM_VEC*PRIO_W | Priority byte of vector v at bits [8v+7:8v] |
| grp_i | input | GRP_W | Priority grouping split point |
| faultmask_i | input | 1 | Fault mask bit of the core |
| primask_i | input | 1 | Global mask bit of the core |
| basepri_i | input | PRIO_W | Base-priority threshold; 0 means off |
| pend_vec_o | output | VEC_W | Selected pending vector number |
| pend_prio_o | output | PRIO_W+2 | Signed priority of the selected vector |
| act_prio_o | output | PRIO_W+2 | Signed, group-masked active priority |
| exec_prio_o | output | PRIO_W+2 | Signed execution priority |
| irq_o | output | 1 | Request toward the core |
| take_o | output | 1 | Pending exception may be taken now |

## Verification
A wrong scan shows up as a mismatched vector number or priority on the very next edge after the table changes. A broken tie-break shows up the same way, but only when two candidates share a priority, so the stimulus deliberately draws priorities from a few coarse steps to make ties common. A wrong group mask or a wrong mask precedence does not show in the vector number at all. It appears only in `act_prio_o`, `exec_prio_o`, and in `take_o` or `irq_o` flipping at a threshold. For that reason the grouping field and the mask inputs are randomised together with active handlers whose priorities carry subpriority bits.

// File: rtl/pga_pkg.sv
package pga_pkg;
  localparam int FIXED_VECS = 3;
  localparam int FIRST_CFG  = FIXED_VECS + 1;
  localparam int NONE_LVL   = 256;

  typedef enum logic [1:0] {
    RUN_FAULT = 2'd0,
    RUN_GLOBAL = 2'd1,
    RUN_BASE  = 2'd2,
    RUN_FREE  = 2'd3
  } run_src_e;

  function automatic int fixed_level(input int v);
    return v - 4; // 1 -> -3, 2 -> -2, 3 -> -1
  endfunction
endpackage

// File: rtl/pga_prio_map.sv
module pga_prio_map
  import pga_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int PRIO_W  = 8,
  localparam int SP_W   = PRIO_W + 2
) (
  input  logic [NUM_VEC*PRIO_W-1:0] prio_i,
  output logic [NUM_VEC*SP_W-1:0]   eff_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    if (v >= 1 && v <= FIXED_VECS) begin : g_fixed
      localparam logic signed [SP_W-1:0] LVL = SP_W'(fixed_level(v));
      assign eff_o[v*SP_W +: SP_W] = LVL;
    end else begin : g_cfg
      assign eff_o[v*SP_W +: SP_W] = {2'b00, prio_i[v*PRIO_W +: PRIO_W]};
    end
  end
endmodule

// File: rtl/pga_pend_scan.sv
module pga_pend_scan
  import pga_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int PRIO_W  = 8,
  localparam int SP_W   = PRIO_W + 2,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]      cand_i,
  input  logic [NUM_VEC*SP_W-1:0] eff_i,
  output logic [VEC_W-1:0]        vec_o,
  output logic signed [SP_W-1:0]  prio_o
);
  always_comb begin
    logic signed [SP_W-1:0] best;
    logic [VEC_W-1:0] best_v;
    best   = SP_W'(NONE_LVL);
    best_v = '0;
    // ascending scan, strict compare: lowest number wins ties
    for (int v = 1; v < NUM_VEC; v++) begin
      if (cand_i[v] && ($signed(eff_i[v*SP_W +: SP_W]) < best)) begin
        best   = $signed(eff_i[v*SP_W +: SP_W]);
        best_v = VEC_W'(v);
      end
    end
    vec_o  = best_v;
    prio_o = best;
  end
endmodule

// File: rtl/pga_act_scan.sv
module pga_act_scan
  import pga_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int PRIO_W  = 8,
  localparam int SP_W   = PRIO_W + 2
) (
  input  logic [NUM_VEC-1:0]      act_i,
  input  logic [NUM_VEC*SP_W-1:0] eff_i,
  input  logic [SP_W-1:0]         gmask_i,
  output logic signed [SP_W-1:0]  act_prio_o
);
  always_comb begin
    logic signed [SP_W-1:0] lo;
    lo = SP_W'(NONE_LVL);
    for (int v = 1; v < NUM_VEC; v++) begin
      if (act_i[v] && ($signed(eff_i[v*SP_W +: SP_W]) < lo))
        lo = $signed(eff_i[v*SP_W +: SP_W]);
    end
    act_prio_o = lo & $signed(gmask_i);
  end
endmodule

// File: rtl/pga_run_prio.sv
module pga_run_prio
  import pga_pkg::*;
#(
  parameter int PRIO_W = 8,
  localparam int SP_W  = PRIO_W + 2
) (
  input  logic                   faultmask_i,
  input  logic                   primask_i,
  input  logic [PRIO_W-1:0]      basepri_i,
  input  logic [SP_W-1:0]        gmask_i,
  input  logic signed [SP_W-1:0] act_prio_i,
  output logic signed [SP_W-1:0] exec_prio_o
);
  run_src_e src;
  logic signed [SP_W-1:0] run_lvl;

  always_comb begin
    if (faultmask_i)           src = RUN_FAULT;
    else if (primask_i)        src = RUN_GLOBAL;
    else if (basepri_i != '0)  src = RUN_BASE;
    else                       src = RUN_FREE;
  end

  always_comb begin
    unique case (src)
      RUN_FAULT:  run_lvl = -SP_W'(1);
      RUN_GLOBAL: run_lvl = '0;
      RUN_BASE:   run_lvl = $signed({2'b00, basepri_i} & gmask_i);
      default:    run_lvl = SP_W'(NONE_LVL);
    endcase
    exec_prio_o = (run_lvl < act_prio_i) ? run_lvl : act_prio_i;
  end
endmodule

// File: rtl/pgrp_irq_arb.sv
module pgrp_irq_arb
  import pga_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int PRIO_W  = 8,
  parameter int GRP_W   = 3,
  localparam int SP_W   = PRIO_W + 2,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_VEC-1:0]        vec_en_i,
  input  logic [NUM_VEC-1:0]        vec_pend_i,
  input  logic [NUM_VEC-1:0]        vec_act_i,
  input  logic [NUM_VEC*PRIO_W-1:0] prio_i,
  input  logic [GRP_W-1:0]          grp_i,
  input  logic                      faultmask_i,
  input  logic                      primask_i,
  input  logic [PRIO_W-1:0]         basepri_i,
  output logic [VEC_W-1:0]          pend_vec_o,
  output logic [SP_W-1:0]           pend_prio_o,
  output logic [SP_W-1:0]           act_prio_o,
  output logic [SP_W-1:0]           exec_prio_o,
  output logic                      irq_o,
  output logic                      take_o
);
  logic [NUM_VEC*SP_W-1:0] eff;
  logic [SP_W-1:0]         gmask;
  logic [VEC_W-1:0]        sel_vec;
  logic signed [SP_W-1:0]  sel_prio, act_lvl, exec_lvl;

  assign gmask = {SP_W{1'b1}} << ({1'b0, grp_i} + 1'b1);

  pga_prio_map #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_map (
    .prio_i(prio_i), .eff_o(eff));

  pga_pend_scan #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_pend (
    .cand_i(vec_en_i & vec_pend_i), .eff_i(eff),
    .vec_o(sel_vec), .prio_o(sel_prio));

  pga_act_scan #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_act (
    .act_i(vec_act_i), .eff_i(eff), .gmask_i(gmask), .act_prio_o(act_lvl));

  pga_run_prio #(.PRIO_W(PRIO_W)) u_run (
    .faultmask_i(faultmask_i), .primask_i(primask_i), .basepri_i(basepri_i),
    .gmask_i(gmask), .act_prio_i(act_lvl), .exec_prio_o(exec_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vec_o  <= '0;
      pend_prio_o <= SP_W'(NONE_LVL);
      act_prio_o  <= SP_W'(NONE_LVL);
      exec_prio_o <= SP_W'(NONE_LVL);
      irq_o       <= 1'b0;
      take_o      <= 1'b0;
    end else begin
      pend_vec_o  <= sel_vec;
      pend_prio_o <= sel_prio;
      act_prio_o  <= act_lvl;
      exec_prio_o <= exec_lvl;
      irq_o       <= sel_prio < act_lvl;
      take_o      <= exec_lvl > sel_prio;
    end
  end

  // R2
  sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec_o != '0) == (pend_prio_o != SP_W'(NONE_LVL)));
  // R7
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_vec_o != '0));
  // R8
  take_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (pend_vec_o != '0));
  // R6
  exec_not_above_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(exec_prio_o) <= $signed(act_prio_o));
  // R9
  sel_had_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec_o != '0) |-> ($past((vec_en_i & vec_pend_i) >> 1) != '0));
endmodule

// File: tb/pgrp_irq_arb_tb.sv
module pgrp_irq_arb_tb;
  localparam int N = 32;
  localparam int PW = 8;
  localparam int SW = PW + 2;
  localparam int VW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] en, pend, act;
  logic [N*PW-1:0] prio;
  logic [2:0] grp;
  logic fm, pm;
  logic [PW-1:0] bp;
  logic [VW-1:0] pend_vec_o;
  logic [SW-1:0] pend_prio_o, act_prio_o, exec_prio_o;
  logic irq_o, take_o;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pgrp_irq_arb #(.NUM_VEC(N), .PRIO_W(PW), .GRP_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .vec_en_i(en), .vec_pend_i(pend),
    .vec_act_i(act), .prio_i(prio), .grp_i(grp), .faultmask_i(fm),
    .primask_i(pm), .basepri_i(bp), .pend_vec_o(pend_vec_o),
    .pend_prio_o(pend_prio_o), .act_prio_o(act_prio_o),
    .exec_prio_o(exec_prio_o), .irq_o(irq_o), .take_o(take_o));

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic int m_eff(input int v);
    if (v == 1) return -3;
    if (v == 2) return -2;
    if (v == 3) return -1;
    return int'(prio[v*PW +: PW]);
  endfunction

  function automatic int m_mask();
    return ~0 << (int'(grp) + 1);
  endfunction

  function automatic int m_pvec();
    int best = 256, bv = 0;
    for (int v = 1; v < N; v++)
      if (en[v] && pend[v] && m_eff(v) < best) begin best = m_eff(v); bv = v; end
    return bv;
  endfunction

  function automatic int m_pprio();
    int v = m_pvec();
    return (v == 0) ? 256 : m_eff(v);
  endfunction

  function automatic int m_act();
    int lo = 256;
    for (int v = 1; v < N; v++)
      if (act[v] && m_eff(v) < lo) lo = m_eff(v);
    return lo & m_mask();
  endfunction

  function automatic int m_exec();
    int r;
    if (fm) r = -1;
    else if (pm) r = 0;
    else if (bp != 0) r = int'(bp) & m_mask();
    else r = 256;
    return (r < m_act()) ? r : m_act();
  endfunction

  task automatic set_prio(input int v, input int p);
    prio[v*PW +: PW] = PW'(p);
  endtask

  // apply on falling edge, sample 1ns after the next rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string tag);
    int ev, ep, ea, ex;
    ev = m_pvec(); ep = m_pprio(); ea = m_act(); ex = m_exec();
    chk("R2", {tag, " vec"}, int'(pend_vec_o), ev);
    chk("R2", {tag, " pprio"}, int'($signed(pend_prio_o)), ep);
    chk("R5", {tag, " act"}, int'($signed(act_prio_o)), ea);
    chk("R6", {tag, " exec"}, int'($signed(exec_prio_o)), ex);
    chk("R7", {tag, " irq"}, int'(irq_o), int'(ep < ea));
    chk("R8", {tag, " take"}, int'(take_o), int'(ex > ep));
  endtask

  task automatic clear_all();
    @(negedge clk);
    en = '0; pend = '0; act = '0; prio = '0; grp = '0; fm = 0; pm = 0; bp = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    en = '0; pend = '0; act = '0; prio = '0; grp = '0; fm = 0; pm = 0; bp = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1", "vec", int'(pend_vec_o), 0);
    chk("R1", "pprio", int'($signed(pend_prio_o)), 256);
    chk("R1", "act", int'($signed(act_prio_o)), 256);
    chk("R1", "exec", int'($signed(exec_prio_o)), 256);
    chk("R1", "irq", int'(irq_o), 0);
    chk("R1", "take", int'(take_o), 0);
    @(negedge clk); rst_n = 1'b1;
    step();

    // R2 tie: lowest number wins
    clear_all();
    set_prio(5, 8'h40); set_prio(9, 8'h40); set_prio(12, 8'h41);
    en[5] = 1; pend[5] = 1; en[9] = 1; pend[9] = 1; en[12] = 1; pend[12] = 1;
    step();
    chk("R2", "tie vec", int'(pend_vec_o), 5);
    check_all("tie");

    // R2 disabled vector not chosen
    @(negedge clk); en[5] = 0;
    step();
    chk("R2", "disabled vec", int'(pend_vec_o), 9);

    // R3 vector 0 flags ignored
    clear_all();
    en[0] = 1; pend[0] = 1; act[0] = 1;
    step();
    chk("R3", "vec0 pend", int'(pend_vec_o), 0);
    chk("R3", "vec0 act", int'($signed(act_prio_o)), 256);
    chk("R3", "vec0 irq", int'(irq_o), 0);

    // R4 fixed level beats configurable 0, byte ignored
    clear_all();
    set_prio(2, 8'hff); set_prio(4, 8'h00);
    en[2] = 1; pend[2] = 1; en[4] = 1; pend[4] = 1;
    step();
    chk("R4", "fixed vec", int'(pend_vec_o), 2);
    chk("R4", "fixed prio", int'($signed(pend_prio_o)), -2);

    // R5 group mask on active priority (grp=3 -> mask low 4 bits off)
    clear_all();
    set_prio(6, 8'h35); act[6] = 1; grp = 3'd3;
    step();
    chk("R5", "grp act", int'($signed(act_prio_o)), 8'h30);
    // same group, lower sub: no preemption (R7)
    @(negedge clk); set_prio(7, 8'h31); en[7] = 1; pend[7] = 1;
    step();
    chk("R7", "same group irq", int'(irq_o), 0);
    @(negedge clk); set_prio(7, 8'h2f);
    step();
    chk("R7", "higher group irq", int'(irq_o), 1);

    // R6 mask precedence
    @(negedge clk); bp = 8'h47; grp = 3'd2;
    step();
    chk("R6", "basepri", int'($signed(exec_prio_o)), 8'h30);
    @(negedge clk); act = '0;
    step();
    chk("R6", "basepri masked", int'($signed(exec_prio_o)), 8'h40);
    @(negedge clk); pm = 1;
    step();
    chk("R6", "primask", int'($signed(exec_prio_o)), 0);
    chk("R8", "primask take", int'(take_o), 0);
    chk("R7", "irq ignores mask", int'(irq_o), 1);
    @(negedge clk); fm = 1;
    step();
    chk("R6", "faultmask", int'($signed(exec_prio_o)), -1);
    @(negedge clk); fm = 0; pm = 0; bp = 0;
    step();
    chk("R8", "free take", int'(take_o), 1);

    // R9 output holds until the edge
    @(negedge clk); pend[7] = 0;
    #1;
    chk("R9", "before edge", int'(pend_vec_o), 7);
    step();
    chk("R9", "after edge", int'(pend_vec_o), 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      en = N'({$urandom, $urandom}) | N'($urandom);
      pend = N'($urandom) & N'($urandom) & N'($urandom);
      act = N'($urandom) & N'($urandom) & N'($urandom) & N'($urandom);
      for (int v = 0; v < N; v++)
        set_prio(v, (it % 2 == 0) ? int'($urandom_range(0, 7)) << 5 : int'($urandom_range(0, 255)));
      grp = 3'($urandom_range(0, 7));
      fm = ($urandom_range(0, 7) == 0);
      pm = ($urandom_range(0, 5) == 0);
      bp = ($urandom_range(0, 1) == 0) ? '0 : PW'($urandom);
      step();
      check_all("rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule